// File: doc/BRIEF.md
# Rule Engine Operand Register File

This block holds the operand storage of a packet rule engine, apart from the header base pointers. It has eight general registers that the engine can read and write, and eight constants that only the host can load. The engine reads the constants through the same operand selector as the general registers. It also holds four single-bit flags that keep comparison outcomes. Two combinational read ports each take a 4-bit operand selector. One write port updates the general registers on the next clock edge. A separate flag write port stores one of four flag sources into a chosen flag.

The upper four general registers also form a log record. This record is always visible on a wide tap, so a log writer outside the block can copy it without taking a read port. The block has no state machine. It is made of three storage banks and two read multiplexers. Every write takes effect at the rising clock edge that follows the cycle in which it is presented. Reads show the registers as they stand during the current cycle.

Top module: `opnd_regfile`

## Requirements
- R1: After an active-low reset, every general register, constant and flag reads as zero, and the log tap is zero.
- R2: When `eng_wr_en` is 1 and `eng_wr_sel` is 0 to 7, `eng_wr_data` is stored into general register `eng_wr_sel` at the next rising edge. Both read ports then return the new value for that selector.
- R3: Read selector values 0 to 7 return general registers 0 to 7. Values 8 to 15 return constants 0 to 7 (constant = selector minus 8).
- R4: An engine write with `eng_wr_sel` 8 to 15 is ignored. No general register and no constant changes.
- R5: When `host_wr_en` is 1, `host_wr_data` is stored into constant `host_wr_idx` at the next rising edge. Engine writes never change a constant.
- R6: A read of a general register in the same cycle as a write to that register returns the old value. The new value appears after the edge.
- R7: Flag source code 2'b00 stores `flg_cmp` into flag `flg_idx`.
- R8: Flag source code 2'b01 stores the OR of all four flags, taken before the write.
- R9: Flag source code 2'b10 stores the AND of all four flags, taken before the write.
- R10: Flag source code 2'b11 stores bit 0 of `flg_res` and ignores its other bits.
- R11: `log_rec` equals {R7, R6, R5, R4}, with R4 in bits 31:0 and R7 in bits 127:96.
- R12: A flag write changes only the flag that `flg_idx` selects. `flags` shows T0 in bit 0 through T3 in bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 4 | Operand selector, read port A |
| rd_a_data | output | 32 | Operand value, read port A |
| rd_b_sel | input | 4 | Operand selector, read port B |
| rd_b_data | output | 32 | Operand value, read port B |
| eng_wr_en | input | 1 | Engine write enable |
| eng_wr_sel | input | 4 | Engine write target selector |
| eng_wr_data | input | 32 | Engine write data |
| flg_we | input | 1 | Flag write enable |
| flg_idx | input | 2 | Flag write target |
| flg_src | input | 2 | Flag source code |
| flg_cmp | input | 1 | Comparison bit |
| flg_res | input | 32 | 32-bit result; only bit 0 is used |
| flags | output | 4 | Current flags T3..T0 |
| host_wr_en | input | 1 | Host constant write enable |
| host_wr_idx | input | 3 | Host constant index |
| host_wr_data | input | 32 | Host constant data |
| log_rec | output | 128 | Log record {R7,R6,R5,R4} |

## Verification
Each general register and each constant is loaded with a distinct pattern. Every selector is then read on both ports, which exposes any swap between register indices or between the two banks. Writes aimed at constant selectors carry a pattern that appears nowhere else, so a write that leaks into either bank shows up on readback. The flag sequence first leaves the flags in mixed states, where OR and AND give different results. It then gives the AND source a set where all flags are 1, and drives `flg_res` with even values that have high bits set. This separates the four sources from one another and catches a result bit taken from the wrong position.

// File: rtl/opnd_regfile_pkg.sv
package opnd_regfile_pkg;
    // Source codes for the flag write port
    typedef enum logic [1:0] {
        FSRC_CMP = 2'b00,
        FSRC_OR  = 2'b01,
        FSRC_AND = 2'b10,
        FSRC_LSB = 2'b11
    } flag_src_e;
endpackage

// File: rtl/opnd_gpr_bank.sv
module opnd_gpr_bank #(
    parameter int DATA_W = 32,
    parameter int NUM_REGS = 8,
    localparam int IDX_W = $clog2(NUM_REGS),
    localparam int SEL_W = IDX_W + 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SEL_W-1:0]                 wr_sel,
    input  logic [DATA_W-1:0]                wr_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q
);
    // The top selector bit picks the constant bank, which this bank never takes
    logic gpr_hit;
    assign gpr_hit = wr_en && !wr_sel[SEL_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else if (gpr_hit) begin
            regs_q[wr_sel[IDX_W-1:0]] <= wr_data;
        end
    end

    // R2: a write to a general register lands at the next edge
    a_r2_gpr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel[SEL_W-1]) |=> regs_q[$past(wr_sel[IDX_W-1:0])] == $past(wr_data));

    // R4: a write aimed at a constant selector leaves the bank untouched
    a_r4_const_sel_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel[SEL_W-1]) |=> $stable(regs_q));
endmodule

// File: rtl/opnd_const_bank.sv
module opnd_const_bank #(
    parameter int DATA_W = 32,
    parameter int NUM_REGS = 8,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             host_we,
    input  logic [IDX_W-1:0]                 host_idx,
    input  logic [DATA_W-1:0]                host_data,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  consts_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            consts_q <= '0;
        end else if (host_we) begin
            consts_q[host_idx] <= host_data;
        end
    end

    // R5: a host write lands at the next edge
    a_r5_host_write: assert property (@(posedge clk) disable iff (!rst_n)
        host_we |=> consts_q[$past(host_idx)] == $past(host_data));

    // R5: without a host write the constants hold
    a_r5_const_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we |=> $stable(consts_q));
endmodule

// File: rtl/opnd_rd_mux.sv
module opnd_rd_mux #(
    parameter int DATA_W = 32,
    parameter int NUM_REGS = 8,
    localparam int IDX_W = $clog2(NUM_REGS),
    localparam int SEL_W = IDX_W + 1
) (
    input  logic [SEL_W-1:0]                 sel,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  gpr,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  consts,
    output logic [DATA_W-1:0]                data
);
    logic [IDX_W-1:0] idx;
    assign idx = sel[IDX_W-1:0];

    always_comb begin
        if (sel[SEL_W-1]) data = consts[idx];
        else              data = gpr[idx];
    end
endmodule

// File: rtl/opnd_flag_unit.sv
module opnd_flag_unit
    import opnd_regfile_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NUM_FLAGS = 4,
    localparam int FIDX_W = $clog2(NUM_FLAGS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [FIDX_W-1:0]     idx,
    input  logic [1:0]            src,
    input  logic                  cmp,
    input  logic [DATA_W-1:0]     res,
    output logic [NUM_FLAGS-1:0]  flags_q
);
    flag_src_e src_e;
    logic      src_bit;

    assign src_e = flag_src_e'(src);

    always_comb begin
        unique case (src_e)
            FSRC_CMP: src_bit = cmp;
            FSRC_OR:  src_bit = |flags_q;
            FSRC_AND: src_bit = &flags_q;
            FSRC_LSB: src_bit = res[0];
            default:  src_bit = cmp;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (we) begin
            flags_q[idx] <= src_bit;
        end
    end

    // R7: the compare bit is stored
    a_r7_cmp_src: assert property (@(posedge clk) disable iff (!rst_n)
        (we && src == 2'b00) |=> flags_q[$past(idx)] == $past(cmp));

    // R8: the OR of the prior flags is stored
    a_r8_or_src: assert property (@(posedge clk) disable iff (!rst_n)
        (we && src == 2'b01) |=> flags_q[$past(idx)] == (|$past(flags_q)));

    // R9: the AND of the prior flags is stored
    a_r9_and_src: assert property (@(posedge clk) disable iff (!rst_n)
        (we && src == 2'b10) |=> flags_q[$past(idx)] == (&$past(flags_q)));

    // R10: only the low bit of the result is stored
    a_r10_lsb_src: assert property (@(posedge clk) disable iff (!rst_n)
        (we && src == 2'b11) |=> flags_q[$past(idx)] == $past(res[0]));

    // R12: flags other than the target hold
    a_r12_other_flags: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((flags_q ^ $past(flags_q)) & ~(NUM_FLAGS'(1) << $past(idx))) == '0);

    a_r12_no_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(flags_q));
endmodule

// File: rtl/opnd_regfile.sv
module opnd_regfile #(
    parameter int DATA_W = 32,
    parameter int NUM_REGS = 8,
    parameter int NUM_FLAGS = 4,
    parameter int LOG_BASE = 4,
    localparam int IDX_W = $clog2(NUM_REGS),
    localparam int SEL_W = IDX_W + 1,
    localparam int FIDX_W = $clog2(NUM_FLAGS),
    localparam int LOG_N = NUM_REGS - LOG_BASE,
    localparam int LOG_W = LOG_N * DATA_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     rd_a_sel,
    output logic [DATA_W-1:0]    rd_a_data,
    input  logic [SEL_W-1:0]     rd_b_sel,
    output logic [DATA_W-1:0]    rd_b_data,
    input  logic                 eng_wr_en,
    input  logic [SEL_W-1:0]     eng_wr_sel,
    input  logic [DATA_W-1:0]    eng_wr_data,
    input  logic                 flg_we,
    input  logic [FIDX_W-1:0]    flg_idx,
    input  logic [1:0]           flg_src,
    input  logic                 flg_cmp,
    input  logic [DATA_W-1:0]    flg_res,
    output logic [NUM_FLAGS-1:0] flags,
    input  logic                 host_wr_en,
    input  logic [IDX_W-1:0]     host_wr_idx,
    input  logic [DATA_W-1:0]    host_wr_data,
    output logic [LOG_W-1:0]     log_rec
);
    logic [NUM_REGS-1:0][DATA_W-1:0] gpr_q;
    logic [NUM_REGS-1:0][DATA_W-1:0] const_q;

    opnd_gpr_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (eng_wr_en),
        .wr_sel  (eng_wr_sel),
        .wr_data (eng_wr_data),
        .regs_q  (gpr_q)
    );

    opnd_const_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_const (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (host_wr_en),
        .host_idx  (host_wr_idx),
        .host_data (host_wr_data),
        .consts_q  (const_q)
    );

    opnd_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_a (
        .sel    (rd_a_sel),
        .gpr    (gpr_q),
        .consts (const_q),
        .data   (rd_a_data)
    );

    opnd_rd_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_b (
        .sel    (rd_b_sel),
        .gpr    (gpr_q),
        .consts (const_q),
        .data   (rd_b_data)
    );

    opnd_flag_unit #(.DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (flg_we),
        .idx     (flg_idx),
        .src     (flg_src),
        .cmp     (flg_cmp),
        .res     (flg_res),
        .flags_q (flags)
    );

    // Log record: lowest logged register in the lowest slice
    for (genvar g = 0; g < LOG_N; g++) begin : g_log
        assign log_rec[g*DATA_W +: DATA_W] = gpr_q[LOG_BASE + g];
    end

    // R6: a read during a write to the same register shows the stored value
    a_r6_read_old: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_wr_en && rd_a_sel == eng_wr_sel && !eng_wr_sel[SEL_W-1] && eng_wr_data != rd_a_data)
        |=> rd_a_sel != $past(rd_a_sel) || rd_a_data != $past(rd_a_data));
endmodule

// File: tb/opnd_regfile_tb_top.sv
`timescale 1ns/1ps
module opnd_regfile_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [3:0]   rd_a_sel = '0, rd_b_sel = '0;
    logic [31:0]  rd_a_data, rd_b_data;
    logic         eng_wr_en = 1'b0;
    logic [3:0]   eng_wr_sel = '0;
    logic [31:0]  eng_wr_data = '0;
    logic         flg_we = 1'b0;
    logic [1:0]   flg_idx = '0, flg_src = '0;
    logic         flg_cmp = 1'b0;
    logic [31:0]  flg_res = '0;
    logic [3:0]   flags;
    logic         host_wr_en = 1'b0;
    logic [2:0]   host_wr_idx = '0;
    logic [31:0]  host_wr_data = '0;
    logic [127:0] log_rec;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] gexp [8];
    logic [31:0] cexp [8];

    always #10 clk = ~clk;

    opnd_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data),
        .rd_b_sel(rd_b_sel), .rd_b_data(rd_b_data),
        .eng_wr_en(eng_wr_en), .eng_wr_sel(eng_wr_sel), .eng_wr_data(eng_wr_data),
        .flg_we(flg_we), .flg_idx(flg_idx), .flg_src(flg_src),
        .flg_cmp(flg_cmp), .flg_res(flg_res), .flags(flags),
        .host_wr_en(host_wr_en), .host_wr_idx(host_wr_idx), .host_wr_data(host_wr_data),
        .log_rec(log_rec)
    );

    // {selector, data}
    localparam logic [35:0] WR_VEC [8] = '{
        {4'd0, 32'h1111_0001}, {4'd1, 32'h2222_0002},
        {4'd2, 32'h4444_0004}, {4'd3, 32'h8888_0008},
        {4'd4, 32'hA5A5_0010}, {4'd5, 32'h5A5A_0020},
        {4'd6, 32'hDEAD_0040}, {4'd7, 32'hBEEF_0080}
    };

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic eng_write(input logic [3:0] sel, input logic [31:0] d);
        @(negedge clk);
        eng_wr_en = 1'b1; eng_wr_sel = sel; eng_wr_data = d;
        @(negedge clk);
        eng_wr_en = 1'b0;
        #1;
    endtask

    task automatic host_write(input logic [2:0] idx, input logic [31:0] d);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_idx = idx; host_wr_data = d;
        @(negedge clk);
        host_wr_en = 1'b0;
        #1;
    endtask

    task automatic flag_write(input logic [1:0] idx, input logic [1:0] src,
                              input logic cmp, input logic [31:0] res);
        @(negedge clk);
        flg_we = 1'b1; flg_idx = idx; flg_src = src; flg_cmp = cmp; flg_res = res;
        @(negedge clk);
        flg_we = 1'b0;
        #1;
    endtask

    task automatic check_all(input string req);
        for (int s = 0; s < 16; s++) begin
            rd_a_sel = 4'(s);
            rd_b_sel = 4'(15 - s);
            #1;
            chk(req, rd_a_data, (s < 8) ? gexp[s] : cexp[s-8]);
            chk(req, rd_b_data, (15 - s < 8) ? gexp[15-s] : cexp[7-s]);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 8; i++) begin gexp[i] = '0; cexp[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check_all("R1");
        chk("R1 flags", flags, 4'b0000);
        chk("R1 log", log_rec, '0);

        // R5 / R3: load constants, read through selectors 8..15
        for (int i = 0; i < 8; i++) begin
            cexp[i] = 32'hC0_000000 | (32'(i) << 8) | 32'h3C;
            host_write(3'(i), cexp[i]);
        end
        check_all("R3 R5");

        // R2: table of general register writes
        for (int i = 0; i < 8; i++) begin
            eng_write(WR_VEC[i][35:32], WR_VEC[i][31:0]);
            gexp[WR_VEC[i][34:32]] = WR_VEC[i][31:0];
            rd_a_sel = WR_VEC[i][35:32];
            rd_b_sel = WR_VEC[i][35:32];
            #1;
            chk("R2 port A", rd_a_data, WR_VEC[i][31:0]);
            chk("R2 port B", rd_b_data, WR_VEC[i][31:0]);
        end
        check_all("R2 R3");

        // R11: log record layout
        chk("R11", log_rec, {gexp[7], gexp[6], gexp[5], gexp[4]});

        // R4: engine writes to constant selectors are dropped
        eng_write(4'd8, 32'hFFFF_0BAD);
        eng_write(4'd13, 32'hFFFF_1BAD);
        eng_write(4'd15, 32'hFFFF_2BAD);
        check_all("R4");

        // R5: host update replaces one constant only
        cexp[5] = 32'h0BAD_F00D;
        host_write(3'd5, cexp[5]);
        check_all("R5");

        // R6: same-cycle read returns the old value
        @(negedge clk);
        eng_wr_en = 1'b1; eng_wr_sel = 4'd3; eng_wr_data = 32'h3333_3333;
        rd_a_sel = 4'd3;
        #1;
        chk("R6 old", rd_a_data, gexp[3]);
        @(negedge clk);
        eng_wr_en = 1'b0;
        gexp[3] = 32'h3333_3333;
        #1;
        chk("R6 new", rd_a_data, 32'h3333_3333);

        // Flags, encoding: src 00 cmp, 01 OR, 10 AND, 11 result bit 0
        flag_write(2'd0, 2'b00, 1'b1, 32'h0);
        chk("R7 T0", flags, 4'b0001);
        flag_write(2'd2, 2'b00, 1'b1, 32'hFFFF_FFFF);
        chk("R7 R12 T2", flags, 4'b0101);
        flag_write(2'd3, 2'b01, 1'b0, 32'h0);
        chk("R8 OR", flags, 4'b1101);
        flag_write(2'd1, 2'b10, 1'b1, 32'h1);
        chk("R9 AND mixed", flags, 4'b1101);
        flag_write(2'd1, 2'b11, 1'b0, 32'h0000_0001);
        chk("R10 lsb one", flags, 4'b1111);
        flag_write(2'd2, 2'b10, 1'b0, 32'h0);
        chk("R9 AND full", flags, 4'b1111);
        flag_write(2'd0, 2'b11, 1'b1, 32'hFFFF_FFFE);
        chk("R10 lsb zero", flags, 4'b1110);
        flag_write(2'd3, 2'b10, 1'b1, 32'h1);
        chk("R9 R12", flags, 4'b0110);
        flag_write(2'd1, 2'b00, 1'b0, 32'h1);
        flag_write(2'd2, 2'b00, 1'b0, 32'h1);
        chk("R7 clear", flags, 4'b0000);
        flag_write(2'd0, 2'b01, 1'b1, 32'h1);
        chk("R8 OR zero", flags, 4'b0000);

        finish_run();
    end
endmodule